// File: doc/BRIEF.md
# Serial GPIO Shift-Chain Controller

This controller multiplies the number of general-purpose lines available to a chip by streaming them over four pins into and out of a chain of external shift registers. It holds an output bank, driven into the chain, and an input bank, sampled from it. Each bank has up to 128 lines. A line is named by a port number (0 to 31) and a bit index inside that port, and its position in either bank vector is `port*4 + bit`.

The host sets four things:
- a 32-bit port-enable mask, where bit p set means port p is in the stream (an inclusive range of ports is simply a run of set bits);
- the number of bits carried by each port;
- a clock divider;
- the output bank values.

While enabled, the controller repeats frames without a break. Each frame walks the enabled ports in ascending order, and the bits of each port in ascending order. On every serial clock it presents one output bit and samples one input bit. The frame ends with a load pulse that latches the chain, and the sampled values then replace the input bank in one step.

Top module: `sgpio_chain_ctrl`

## Requirements
- R1: While reset is held and right after it, `sclk`, `sload` and `sdout` are low and `in_bank` is all zeros.
- R2: With D = `clk_div`, or 2 if `clk_div` is below 2, each serial clock lasts D system clocks. It is high for floor(D/2) of them and low for the remaining ceil(D/2).
- R3: A frame has exactly (number of enabled ports) × (`bits_per_port`+1) serial clocks. Their order is ascending port, and ascending bit index within a port; `bits_per_port` encodes bit count minus one.
- R4: Ports whose mask bit is 0 get no serial clocks. `in_bank` positions of disabled ports, and positions with a bit index above `bits_per_port`, read 0 after a frame.
- R5: At the rising `sclk` edge for (port p, bit b), `sdout` equals `out_bank[p*4+b]`. `sdout` does not change while `sclk` is high.
- R6: After a frame, `in_bank[p*4+b]` holds the `sdin` value present just before the rising `sclk` edge for (p, b).
- R7: After the last bit of a frame, `sload` is high for exactly D system clocks with `sclk` low. `in_bank` changes only in the cycle after a load cycle.
- R8: Frames follow each other while `enable` is high. The frame uses the output values taken at its start, so a change to `out_bank` during a frame appears only in the next frame.
- R9: One cycle after `enable` is low, `sclk`, `sload` and `sdout` are low, and `in_bank` keeps its last value, even when a frame is cut off.
- R10: With an all-zero port mask and `enable` high, `sload` stays high, `sclk` never pulses and `in_bank` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run frames continuously while high |
| port_en | input | 32 | Port mask; bit p set puts port p in the stream |
| bits_per_port | input | 2 | Bits carried per port, minus one |
| clk_div | input | 16 | System clocks per serial clock (values below 2 act as 2) |
| out_bank | input | 128 | Output line values, position port*4+bit |
| in_bank | output | 128 | Input line values captured by the last completed frame |
| sclk | output | 1 | Serial clock to the chain |
| sload | output | 1 | Load pulse that latches the chain at frame end |
| sdout | output | 1 | Serial data toward the chain |
| sdin | input | 1 | Serial data returning from the chain |

## Verification
The stimulus uses three kinds of port mask:
- scattered ranges, including ones shaped like a sparse board layout;
- a full mask and a single top port;
- an empty mask.

Together these separate correct port skipping from off-by-one walks and from frames that never end. Bit counts of 1 to 4 and dividers from 0 to 7 expose any error in the bank index arithmetic and in the high/low split of odd divisors. Each frame uses random output and input vectors, so a swapped or shifted bit shows up as a mismatch in both the serial stream and the input bank. Output writes in the middle of a frame, and disabling in the middle of a frame, check the snapshot and hold behaviour.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } chain_st_e;
endpackage

// File: rtl/sgpio_bit_clock.sv
module sgpio_bit_clock #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            sclk_lvl,
    output logic            rise,
    output logic            wrap
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic            lvl;
    } bclk_t;

    bclk_t q, d;
    logic [DIVW-1:0] eff, lo_len;

    always_comb begin
        // divisor floor of 2 keeps the serial rate at or below half the system clock
        eff    = (div < DIVW'(2)) ? DIVW'(2) : div;
        lo_len = eff - (eff >> 1);
        wrap   = run && (q.cnt >= eff - DIVW'(1));
        rise   = run && (q.cnt == lo_len - DIVW'(1));
        d      = q;
        d.cnt  = !run ? '0 : (wrap ? '0 : q.cnt + DIVW'(1));
        d.lvl  = run && (d.cnt >= lo_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_lvl = q.lvl;
endmodule

// File: rtl/sgpio_port_seek.sv
module sgpio_port_seek #(
    parameter int NPORT = 32,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic [NPORT-1:0] mask,
    input  logic [PW:0]      from,
    output logic             found,
    output logic [PW-1:0]    port
);
    // lowest enabled port at or above 'from'
    always_comb begin
        found = 1'b0;
        port  = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                port  = PW'(i);
            end
        end
    end
endmodule

// File: rtl/sgpio_chain_ctrl.sv
module sgpio_chain_ctrl
    import sgpio_pkg::*;
#(
    parameter int NPORT   = 32,
    parameter int BPP_MAX = 4,
    parameter int DIVW    = 16,
    localparam int PW     = $clog2(NPORT),
    localparam int BW     = $clog2(BPP_MAX),
    localparam int NLINE  = NPORT * BPP_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NPORT-1:0] port_en,
    input  logic [BW-1:0]    bits_per_port,
    input  logic [DIVW-1:0]  clk_div,
    input  logic [NLINE-1:0] out_bank,
    output logic [NLINE-1:0] in_bank,
    output logic             sclk,
    output logic             sload,
    output logic             sdout,
    input  logic             sdin
);
    typedef struct packed {
        chain_st_e        st;
        logic [PW-1:0]    port;
        logic [BW-1:0]    bit_i;
        logic [NLINE-1:0] snap;
        logic [NLINE-1:0] shadow;
        logic [NLINE-1:0] inb;
        logic             sdo;
    } ctrl_t;

    ctrl_t q, d;

    logic          bc_lvl, bc_rise, bc_wrap;
    logic          first_ok, next_ok;
    logic [PW-1:0] first_port, next_port;

    sgpio_bit_clock #(.DIVW(DIVW)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.st != ST_IDLE),
        .div      (clk_div),
        .sclk_lvl (bc_lvl),
        .rise     (bc_rise),
        .wrap     (bc_wrap)
    );

    sgpio_port_seek #(.NPORT(NPORT)) u_seek_first (
        .mask  (port_en),
        .from  ('0),
        .found (first_ok),
        .port  (first_port)
    );

    sgpio_port_seek #(.NPORT(NPORT)) u_seek_next (
        .mask  (port_en),
        .from  ({1'b0, q.port} + (PW+1)'(1)),
        .found (next_ok),
        .port  (next_port)
    );

    always_comb begin
        logic start;
        d     = q;
        start = 1'b0;
        unique case (q.st)
            ST_IDLE: start = enable;
            ST_SHIFT: begin
                if (bc_rise) d.shadow[{q.port, q.bit_i}] = sdin;
                if (bc_wrap) begin
                    if (q.bit_i >= bits_per_port) begin
                        if (next_ok) begin
                            d.port  = next_port;
                            d.bit_i = '0;
                            d.sdo   = q.snap[{next_port, BW'(0)}];
                        end else begin
                            d.st  = ST_LOAD;
                            d.sdo = 1'b0;
                        end
                    end else begin
                        d.bit_i = q.bit_i + BW'(1);
                        d.sdo   = q.snap[{q.port, q.bit_i + BW'(1)}];
                    end
                end
            end
            ST_LOAD: begin
                if (bc_wrap) begin
                    d.inb = q.shadow;
                    start = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (start) begin
            d.snap   = out_bank;
            d.shadow = '0;
            d.bit_i  = '0;
            if (first_ok) begin
                d.st   = ST_SHIFT;
                d.port = first_port;
                d.sdo  = out_bank[{first_port, BW'(0)}];
            end else begin
                d.st  = ST_LOAD;
                d.sdo = 1'b0;
            end
        end
        if (!enable) begin
            d.st  = ST_IDLE;
            d.sdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sclk    = bc_lvl && (q.st == ST_SHIFT);
    assign sload   = (q.st == ST_LOAD);
    assign sdout   = q.sdo;
    assign in_bank = q.inb;
endmodule

// File: rtl/sgpio_chain_chk.sv
module sgpio_chain_chk #(
    parameter int NLINE = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sclk,
    input logic             sload,
    input logic             sdout,
    input logic [NLINE-1:0] in_bank
);
    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk && sload));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sclk && !sload && !sdout));

    // R5
    sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdout));

    // R7
    inbank_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_bank) |-> $past(sload));
endmodule

bind sgpio_chain_ctrl sgpio_chain_chk #(.NLINE(NLINE)) u_chain_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .sclk    (sclk),
    .sload   (sload),
    .sdout   (sdout),
    .in_bank (in_bank)
);

// File: tb/test_sgpio_chain_ctrl.sv
module test_sgpio_chain_ctrl;
    localparam int NLINE = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [31:0]  port_en = '0;
    logic [1:0]   bits_per_port = '0;
    logic [15:0]  clk_div = 16'd2;
    logic [127:0] out_bank = '0;
    logic [127:0] in_bank;
    logic         sclk, sload, sdout;
    logic         sdin = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sgpio_chain_ctrl i_sgpio_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .port_en(port_en),
        .bits_per_port(bits_per_port), .clk_div(clk_div), .out_bank(out_bank),
        .in_bank(in_bank), .sclk(sclk), .sload(sload), .sdout(sdout), .sdin(sdin)
    );

    // external chain model: records sdout at each rise, presents next input bit
    int           rcnt = 0;
    int           last_cnt = 0;
    logic [127:0] got = '0;
    logic [127:0] last_got = '0;
    logic [127:0] in_vec = '0;

    always @(posedge sclk) begin
        if (rcnt < 128) got[rcnt] = sdout;
        rcnt = rcnt + 1;
        sdin = in_vec[(rcnt < 128) ? rcnt : 0];
    end

    always @(posedge sload) begin
        last_got = got;
        last_cnt = rcnt;
        rcnt = 0;
        sdin = in_vec[0];
    end

    int ordv [0:127];
    int nord;

    function automatic void build_order(input logic [31:0] pe, input int nb);
        nord = 0;
        for (int p = 0; p < 32; p++)
            if (pe[p])
                for (int b = 0; b < nb; b++) begin
                    ordv[nord] = p * 4 + b;
                    nord++;
                end
    endfunction

    function automatic logic [127:0] exp_stream(input logic [127:0] ob);
        logic [127:0] r = '0;
        for (int k = 0; k < nord; k++) r[k] = ob[ordv[k]];
        return r;
    endfunction

    function automatic logic [127:0] exp_inbank(input logic [127:0] v);
        logic [127:0] r = '0;
        for (int k = 0; k < nord; k++) r[ordv[k]] = v[k];
        return r;
    endfunction

    function automatic logic [127:0] low_mask(input int n);
        logic [127:0] r = '0;
        for (int k = 0; k < n; k++) r[k] = 1'b1;
        return r;
    endfunction

    function automatic int eff_div(input logic [15:0] dv);
        return (dv < 2) ? 2 : int'(dv);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input logic [31:0] pe, input logic [1:0] nbm1, input logic [15:0] dv,
                       input logic [127:0] ob, input logic [127:0] iv);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        port_en = pe; bits_per_port = nbm1; clk_div = dv; out_bank = ob;
        in_vec = iv; rcnt = 0; got = '0; sdin = iv[0];
        build_order(pe, int'(nbm1) + 1);
        @(negedge clk);
        enable = 1'b1;
    endtask

    // run one frame, check stream, load pulse and input bank
    task automatic frame_test(input logic [31:0] pe, input logic [1:0] nbm1, input logic [15:0] dv);
        logic [127:0] ob, iv, m, e_in;
        int lcnt;
        bit sclk_seen;
        ob = {$urandom, $urandom, $urandom, $urandom};
        iv = {$urandom, $urandom, $urandom, $urandom};
        arm(pe, nbm1, dv, ob, iv);
        @(posedge sload); #1;
        m = low_mask(nord);
        chk(last_cnt == nord, "R3 serial clock count", 128'(last_cnt), 128'(nord));
        chk((last_got & m) == exp_stream(ob), "R5 sdout order", last_got & m, exp_stream(ob));
        lcnt = 0; sclk_seen = 0;
        forever begin
            @(negedge clk);
            if (!sload) break;
            lcnt++;
            if (sclk) sclk_seen = 1;
        end
        chk(lcnt == eff_div(dv) && !sclk_seen, "R7 load pulse length", 128'(lcnt), 128'(eff_div(dv)));
        e_in = exp_inbank(iv);
        chk(in_bank == e_in, "R6 R4 input bank", in_bank, e_in);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sclk && !sload && !sdout && in_bank == e_in, "R9 idle after disable",
            {in_bank[124:0], sclk, sload, sdout}, {e_in[124:0], 3'b000});
    endtask

    task automatic duty_test(input logic [15:0] dv);
        int hi, lo;
        arm(32'hFFFF_FFFF, 2'd3, dv, '0, '0);
        @(posedge sclk);
        hi = 0;
        do begin @(negedge clk); if (sclk) hi++; end while (sclk);
        lo = 1;
        do begin @(negedge clk); if (!sclk) lo++; end while (!sclk);
        chk(hi == eff_div(dv) / 2, "R2 high phase", 128'(hi), 128'(eff_div(dv) / 2));
        chk(lo == eff_div(dv) - eff_div(dv) / 2, "R2 low phase", 128'(lo), 128'(eff_div(dv) - eff_div(dv) / 2));
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] a_v, b_v, hold;
        void'($urandom(32'd20201008));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!sclk && !sload && !sdout && in_bank == '0, "R1 reset outputs",
            {in_bank[124:0], sclk, sload, sdout}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk && !sload && !sdout && in_bank == '0, "R1 after reset",
            {in_bank[124:0], sclk, sload, sdout}, '0);

        // directed masks
        frame_test(32'hF007_0001, 2'd2, 16'd4);  // ranges 0, 16-18, 28-31
        frame_test(32'hFFFF_FFFF, 2'd3, 16'd2);  // every line
        frame_test(32'h8000_0000, 2'd0, 16'd0);  // single top port, divider floor
        frame_test(32'h0000_0001, 2'd1, 16'd1);
        // random masks and sizes
        for (int i = 0; i < 8; i++) begin
            logic [31:0] pe;
            pe = $urandom;
            if (pe == 0) pe = 32'h10;
            frame_test(pe, 2'($urandom_range(0, 3)), 16'($urandom_range(2, 7)));
        end

        // R2 duty split for odd and even divisors
        duty_test(16'd5);
        duty_test(16'd6);
        duty_test(16'd3);

        // R8 mid-frame output write shows in next frame only
        a_v = {$urandom, $urandom, $urandom, $urandom};
        b_v = ~a_v;
        arm(32'h0000_0F0F, 2'd3, 16'd3, a_v, '0);
        @(posedge sload); #1;
        repeat (3) @(posedge sclk);
        #1 out_bank = b_v;
        @(posedge sload); #1;
        chk((last_got & low_mask(nord)) == exp_stream(a_v), "R8 frame keeps snapshot",
            last_got & low_mask(nord), exp_stream(a_v));
        @(posedge sload); #1;
        chk((last_got & low_mask(nord)) == exp_stream(b_v), "R8 next frame uses write",
            last_got & low_mask(nord), exp_stream(b_v));

        // R9 disable in mid-frame keeps last bank
        a_v = {$urandom, $urandom, $urandom, $urandom};
        arm(32'h00FF_0000, 2'd3, 16'd4, '0, a_v);
        @(posedge sload);
        @(negedge sload);
        @(negedge clk);
        hold = in_bank;
        in_vec = ~a_v;
        repeat (5) @(posedge sclk);
        @(negedge clk);
        enable = 1'b0;
        repeat (30) @(negedge clk);
        chk(in_bank == hold && !sclk && !sload, "R9 hold on mid-frame disable", in_bank, hold);

        // R10 empty mask: endless load, no clocks, bank reads zero
        arm(32'h0, 2'd3, 16'd3, '1, '1);
        repeat (4) @(negedge clk);
        begin
            bit clk_seen = 0;
            bit load_low = 0;
            repeat (20) begin
                @(negedge clk);
                if (sclk) clk_seen = 1;
                if (!sload) load_low = 1;
            end
            chk(!clk_seen && !load_low && in_bank == '0, "R10 empty mask",
                {in_bank[125:0], clk_seen, load_low}, '0);
        end
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule